// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a very small 8-bit processor built around a single accumulator. It fetches and executes code from a 64-word, 8-bit memory that sits outside the block and is shared between instructions and data. The instruction set has four operations: bitwise NOR, addition with carry-out, store, and a jump taken on a clear carry. Every other operation must be composed from these four. The logic is kept to a handful of registers so that it fits a device with roughly 32 macrocells.

Each instruction word carries a 2-bit opcode in bits 7:6 and a 6-bit operand address in bits 5:0. An instruction takes two clock cycles. In the fetch cycle the program counter is driven onto the address port. In the execute cycle the operand address is driven, and a store raises the write strobe. The memory answers a read on the clock edge after the address is presented. The block therefore commits NOR and ADD results at the end of the next fetch cycle, when the operand arrives.

The memory port is a plain synchronous port with a fixed one-cycle read latency and no back-pressure, so it carries no valid/ready handshake. The memory has to accept an access on every cycle.

Top module: `tiny_acc_cpu`

## Requirements
- R1: A synchronous reset, held across a clock edge, sets the program counter, accumulator and carry to zero. The first cycle after reset is a fetch from address 0 with the write strobe low, and a store executed first writes 0x00.
- R2: An instruction word encodes its opcode in bits 7:6 (00 NOR, 01 ADD, 10 store, 11 jump-if-carry-clear) and its operand address in bits 5:0. In the execute cycle the address port shows the operand address.
- R3: Fetch and execute cycles alternate. A fetch cycle drives the program counter on the address port with the write strobe low, and advances the counter by one.
- R4: NOR replaces the accumulator with the bitwise NOR of the accumulator and the word at the operand address. It leaves the carry unchanged.
- R5: ADD replaces the accumulator with the low 8 bits of accumulator plus operand word. The carry is set to the carry-out of that sum; the previous carry does not enter the sum.
- R6: A store drives the accumulator on the write-data port and raises the write strobe for exactly the execute cycle. Only stores write memory.
- R7: A jump with carry clear makes the next fetch come from the operand address.
- R8: A jump with carry set does not branch. The next fetch is the following word, and the carry is cleared.
- R9: The program counter wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| mem_addr_o | output | 6 | Memory address: program counter in fetch, operand in execute |
| mem_wdata_o | output | 8 | Write data (accumulator) |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |
| mem_we_o | output | 1 | Write strobe, high during a store's execute cycle |

## Verification
The hardest situation to reach from the ports is a jump seen with carry set. It only arises right after an ADD whose sum overflows, and it is seen only as a fall-through plus a later jump that is taken because the carry was cleared. A directed program builds 0xFF with a NOR of zero and then adds 0x01 before two back-to-back jumps. Stores placed around these instructions expose the accumulator and the path taken. The wrap from 63 to 0 needs the counter to walk the whole space, so a second image fills memory with NOR instructions that never jump. Randomly filled images then run through a behavioural model, which checks the address, strobe and write data on every cycle.

// File: rtl/tac_pkg.sv
package tac_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OPC_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOR = 2'b00,
    OPC_ADD = 2'b01,
    OPC_STA = 2'b10,
    OPC_JCC = 2'b11
  } tac_opc_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } tac_phase_e;
endpackage

// File: rtl/tac_alu.sv
module tac_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              add_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] nor_v;

  assign sum = {1'b0, acc_i} + {1'b0, opnd_i};

  for (genvar b = 0; b < DATA_W; b++) begin : g_nor_bit
    assign nor_v[b] = ~(acc_i[b] | opnd_i[b]);
  end

  assign res_o  = add_i ? sum[DATA_W-1:0] : nor_v;
  assign cout_o = add_i & sum[DATA_W];
endmodule

// File: rtl/tac_seq.sv
module tac_seq
  import tac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic              carry_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              store_o,
  output logic              carry_clr_o,
  output logic              commit_o,
  output logic              commit_add_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  tac_phase_e        phase_q;
  logic [ADDR_W-1:0] pc_q;
  logic              pend_q;
  logic              pend_add_q;
  tac_opc_e          opc;
  logic [ADDR_W-1:0] opnd;
  logic              in_exec;

  assign opc     = tac_opc_e'(instr_i[DATA_W-1 -: OPC_W]);
  assign opnd    = instr_i[ADDR_W-1:0];
  assign in_exec = (phase_q == PH_EXEC);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q    <= PH_FETCH;
      pc_q       <= '0;
      pend_q     <= 1'b0;
      pend_add_q <= 1'b0;
    end else if (!in_exec) begin
      phase_q <= PH_EXEC;
      pc_q    <= pc_q + PC_ONE;
      pend_q  <= 1'b0;
    end else begin
      phase_q    <= PH_FETCH;
      pend_q     <= (opc == OPC_NOR) || (opc == OPC_ADD);
      pend_add_q <= (opc == OPC_ADD);
      if (opc == OPC_JCC && !carry_i) pc_q <= opnd;
    end
  end

  assign addr_o       = in_exec ? opnd : pc_q;
  assign store_o      = in_exec && (opc == OPC_STA);
  assign carry_clr_o  = in_exec && (opc == OPC_JCC) && carry_i;
  assign commit_o     = pend_q;
  assign commit_add_o = pend_add_q;

  // R1: reset returns the sequencer to a fetch from address 0
  a_r1_reset_state: assert property (@(posedge clk_i)
    rst_i |=> (pc_q == '0 && phase_q == PH_FETCH && !pend_q));

  // R3: the two phases strictly alternate
  a_r3_exec_after_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));
  a_r3_fetch_after_exec: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));

  // R9: each fetch steps the counter by one modulo the address space
  a_r9_pc_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_FETCH) |=> (pc_q == $past(pc_q) + PC_ONE));

  // R7: a jump with clear carry loads the operand into the counter
  a_r7_jump_taken: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_exec && opc == OPC_JCC && !carry_i) |=> (pc_q == $past(opnd)));

  // R6: a result commit never overlaps a store cycle
  a_r6_commit_not_exec: assert property (@(posedge clk_i) disable iff (rst_i)
    pend_q |-> !store_o);
endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu
  import tac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DATA_W-1:0] acc_q;
  logic              cy_q;
  logic [DATA_W-1:0] alu_res;
  logic              alu_cout;
  logic              commit;
  logic              commit_add;
  logic              carry_clr;

  tac_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .instr_i      (mem_rdata_i),
    .carry_i      (cy_q),
    .addr_o       (mem_addr_o),
    .store_o      (mem_we_o),
    .carry_clr_o  (carry_clr),
    .commit_o     (commit),
    .commit_add_o (commit_add)
  );

  tac_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_i  (acc_q),
    .opnd_i (mem_rdata_i),
    .add_i  (commit_add),
    .res_o  (alu_res),
    .cout_o (alu_cout)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (commit) begin
      acc_q <= alu_res;
      if (commit_add) cy_q <= alu_cout;
    end else if (carry_clr) begin
      cy_q <= 1'b0;
    end
  end

  assign mem_wdata_o = acc_q;

  // R1: reset clears the accumulator and carry
  a_r1_regs_cleared: assert property (@(posedge clk_i)
    rst_i |=> (acc_q == '0 && !cy_q));

  // R4: without a pending result the accumulator holds its value
  a_r4_acc_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !commit |=> $stable(acc_q));

  // R5: an ADD commit yields the full sum in carry and accumulator
  a_r5_add_sum: assert property (@(posedge clk_i) disable iff (rst_i)
    (commit && commit_add) |=>
      ({cy_q, acc_q} == $past({1'b0, acc_q} + {1'b0, mem_rdata_i})));

  // R4: a NOR commit leaves the carry untouched
  a_r4_nor_keeps_carry: assert property (@(posedge clk_i) disable iff (rst_i)
    (commit && !commit_add) |=> $stable(cy_q));

  // R8: a jump seen with carry set clears the carry
  a_r8_carry_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_clr |=> !cy_q);

  // R6: the write strobe is a single-cycle pulse
  a_r6_we_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/test_tiny_acc_cpu.sv
module test_tiny_acc_cpu;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       mem_we;
  logic       load_req = 1'b0;
  logic [7:0] mem     [64];
  logic [7:0] img     [64];
  logic [7:0] ref_mem [64];
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #2 clk = ~clk;

  tiny_acc_cpu i_tiny_acc_cpu (
    .clk_i       (clk),
    .rst_i       (rst),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we)
  );

  // synchronous memory: one cycle read latency
  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 64; i++) mem[i] <= img[i];
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_prog(int ncyc);
    logic [5:0] pc;
    logic [7:0] acc;
    logic [7:0] ins;
    logic       cy;
    logic       ph;
    string      ftag;
    string      atag;
    rst = 1'b1;
    for (int i = 0; i < 64; i++) ref_mem[i] = img[i];
    @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    @(negedge clk);
    chk("R1", 32'(mem_addr), 32'd0, "address in reset");
    chk("R1", 32'(mem_we), 32'd0, "strobe in reset");
    rst  = 1'b0;
    pc   = '0;
    acc  = '0;
    cy   = 1'b0;
    ph   = 1'b0;
    ins  = '0;
    ftag = "R1";
    atag = "R1";
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) @(negedge clk);
      if (!ph) begin
        chk(ftag, 32'(mem_we), 32'd0, "strobe in fetch");
        chk(ftag, 32'(mem_addr), 32'(pc), "fetch address");
        ins = ref_mem[pc];
        pc  = pc + 6'd1;
        ph  = 1'b1;
      end else begin
        chk("R2", 32'(mem_addr), 32'(ins[5:0]), "operand address");
        chk("R6", 32'(mem_we), 32'(ins[7:6] == 2'b10), "write strobe");
        if (ins[7:6] == 2'b10) chk(atag, 32'(mem_wdata), 32'(acc), "store data");
        ftag = (pc == 6'd0) ? "R9" : "R3";
        case (ins[7:6])
          2'b00: begin acc = ~(acc | ref_mem[ins[5:0]]); atag = "R4"; end
          2'b01: begin {cy, acc} = {1'b0, acc} + {1'b0, ref_mem[ins[5:0]]}; atag = "R5"; end
          2'b10: ref_mem[ins[5:0]] = acc;
          default: begin
            if (!cy) begin pc = ins[5:0]; ftag = "R7"; end
            else begin cy = 1'b0; ftag = "R8"; end
          end
        endcase
        ph = 1'b0;
      end
    end
    rst = 1'b1;
    @(negedge clk);
    chk("R1", 32'(mem_addr), 32'd0, "address after reset");
    for (int i = 0; i < 64; i++) chk("R6", 32'(mem[i]), 32'(ref_mem[i]), "memory word");
  endtask

  initial begin
    // directed image: reset store, overflow, jump with carry set then clear
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    img[0]  = 8'hB1;  // store 49
    img[1]  = 8'h3C;  // NOR 60 -> FF
    img[2]  = 8'h7D;  // ADD 61 -> 00, carry
    img[3]  = 8'hB2;  // store 50
    img[4]  = 8'hCC;  // jump 12, carry set: falls through
    img[5]  = 8'hC8;  // jump 8, carry clear: taken
    img[6]  = 8'hB3;  // store 51, skipped
    img[8]  = 8'h3C;  // NOR 60 -> FF
    img[9]  = 8'h7E;  // ADD 62 -> 04, carry
    img[10] = 8'hB4;  // store 52
    img[11] = 8'hCB;  // falls through
    img[12] = 8'hCC;  // loop
    img[49] = 8'hEE; img[50] = 8'hEE; img[51] = 8'hAA; img[52] = 8'hEE;
    img[60] = 8'h00; img[61] = 8'h01; img[62] = 8'h05;
    run_prog(80);
    chk("R1", 32'(mem[49]), 32'h00, "first store after reset");
    chk("R5", 32'(mem[50]), 32'h00, "overflowing sum");
    chk("R7", 32'(mem[51]), 32'hAA, "skipped store untouched");
    chk("R8", 32'(mem[52]), 32'h04, "fall-through reached store");

    // wrap image: NOR everywhere, counter sweeps all 64 words
    for (int i = 0; i < 64; i++) img[i] = 8'h3F;
    run_prog(300);

    // random images
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
      run_prog(1000);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule